// File: doc/BRIEF.md
# Programmable Down-Counter Timer Channel

This block is one channel of an interval timer. A 16-bit down counter advances on a count-enable pulse (`tick`, one pulse for each period of the timer's count clock) and is qualified by a `gate` input. It drives a single waveform output `out`. A control write selects one of six waveform modes and binary or four-digit BCD counting. A count write supplies the initial value. A latch request copies the live counter into a readback register while counting continues.

Software writes the mode, then the initial count. Depending on the mode, counting starts from the write or from a rising edge on `gate`. The output then gives a level change at terminal count, a one-shot pulse, a periodic one-tick low pulse, a square wave, or a single one-tick strobe. A control write and a count write in the same cycle are both applied, mode first. A `tick` that coincides with either write is not counted. An initial count of 0 means 65536 in binary and 10000 in BCD, and it falls out of the wrap of the down counter. Modes 2 and 3 require a count of at least 2.

Top module: `tmr_channel`

## Requirements
- R1: After reset `out` is 1 and `rd_count` is 0.
- R2: Mode code 0: a control write drives `out` to 0, and a count write of N also drives it to 0. The first following tick loads N. Each later tick with `gate` high decrements the counter. `out` rises on the (N+1)th tick after the count write and stays high until the next write. There is no counting on cycles without `tick`.
- R3: Mode 0: ticks with `gate` low neither decrement the counter nor move `out`. Counting resumes where it stopped when `gate` returns high.
- R4: Mode code 1: a `gate` rising edge arms a trigger that the next tick consumes. That tick loads N and drives `out` to 0. `out` returns to 1 on the Nth tick after the load. A new rising edge, even during the pulse, reloads N and restarts the low pulse.
- R5: Mode 1: a count written during a low pulse does not change that pulse. The new value is used from the next trigger.
- R6: Mode code 2: after a count write, the first tick loads N and `out` is 1. The output then repeats with period N ticks: high for N-1 ticks, low for one tick.
- R7: Mode code 3: `out` is a square wave of period N ticks. It is high for ceil(N/2) ticks and low for floor(N/2) ticks, starting high from the load tick.
- R8: Modes 2 and 3: while `gate` is low, `out` is forced to 1 and counting is held. At a `gate` rising edge the next tick reloads N and restarts the waveform from its high phase.
- R9: Mode code 4: the first tick after a count write loads N. `out` stays 1 except for one tick, on the (N+1)th tick after the write, when it is 0. No further strobe follows without a new count write.
- R10: Mode code 5: nothing happens until a `gate` rising edge. The next tick loads N. `out` is 0 for one tick on the Nth tick after the load, and 1 otherwise.
- R11: Mode codes 6 and 7 behave exactly as codes 2 and 3.
- R12: With `cfg_bcd` = 1 the counter steps through four BCD digits, one digit per nibble with the least significant digit in bits 3:0. 0x0100 decrements to 0x0099, and 0x0000 decrements to 0x9999. In binary, 0x0000 decrements to 0xFFFF.
- R13: A `latch_req` pulse copies the counter into `rd_count`, which then holds that value while counting continues, until the next `latch_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count-clock enable, one pulse per count period |
| gate | input | 1 | Gate level; rising edge is a trigger |
| cfg_wr | input | 1 | Control write strobe |
| cfg_mode | input | 3 | Mode code 0..7 |
| cfg_bcd | input | 1 | 1 selects BCD counting |
| cnt_wr | input | 1 | Initial-count write strobe |
| cnt_val | input | 16 | Initial count |
| latch_req | input | 1 | Snapshot request |
| rd_count | output | 16 | Latched counter snapshot |
| out | output | 1 | Timer waveform output |

## Verification
The waveform modes are driven with short counts, and `out` is checked on every tick. Odd and even counts in mode 3 separate the unequal half periods from the equal ones. Each of modes 2 and 3 is also run under its alias code. `gate` is exercised as a level in modes 0, 2 and 3 and as an edge in modes 1 and 5. The gate tests include a retrigger in the middle of a pulse and a count rewrite in the middle of a pulse, which separate a restart from a continuation. Snapshots taken at digit borrows and at the zero wrap, in both radices, show whether the count steps in BCD or in binary and whether the snapshot freezes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic [2:0] {
        MD_TC_INT    = 3'd0,
        MD_ONESHOT   = 3'd1,
        MD_RATE      = 3'd2,
        MD_SQUARE    = 3'd3,
        MD_SW_STROBE = 3'd4,
        MD_HW_STROBE = 3'd5
    } tmr_mode_e;

    // codes 6 and 7 fold onto the periodic modes
    function automatic tmr_mode_e fold_mode(input logic [2:0] code);
        case (code)
            3'd6:    fold_mode = MD_RATE;
            3'd7:    fold_mode = MD_SQUARE;
            default: fold_mode = tmr_mode_e'(code);
        endcase
    endfunction

endpackage

// File: rtl/tmr_gate_edge.sv
module tmr_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic gate_d, gate_q;

    always_comb gate_d = gate;

    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= gate_d;
    end

    assign rise = gate & ~gate_q;
endmodule

// File: rtl/tmr_step.sv
// One radix-aware step of +/-STEP on a counter value.
module tmr_step #(
    parameter int W    = 16,
    parameter int STEP = 1,
    parameter bit UP   = 1'b0
) (
    input  logic [W-1:0] val,
    input  logic         bcd,
    output logic [W-1:0] res
);
    localparam int NDIG = W / 4;

    logic [W-1:0] bin_res, dec_res;
    logic [4:0]   dig, carry;

    generate
        if (UP) begin : g_up
            always_comb begin
                bin_res = val + W'(STEP);
                carry   = 5'(STEP);
                dig     = '0;
                dec_res = '0;
                for (int i = 0; i < NDIG; i++) begin
                    dig = {1'b0, val[4*i +: 4]} + carry;
                    if (dig > 5'd9) begin
                        dec_res[4*i +: 4] = 4'(dig - 5'd10);
                        carry = 5'd1;
                    end else begin
                        dec_res[4*i +: 4] = dig[3:0];
                        carry = 5'd0;
                    end
                end
            end
        end else begin : g_down
            always_comb begin
                bin_res = val - W'(STEP);
                carry   = 5'(STEP);
                dig     = '0;
                dec_res = '0;
                for (int i = 0; i < NDIG; i++) begin
                    dig = {1'b0, val[4*i +: 4]};
                    if (dig >= carry) begin
                        dec_res[4*i +: 4] = 4'(dig - carry);
                        carry = 5'd0;
                    end else begin
                        dec_res[4*i +: 4] = 4'(dig + 5'd10 - carry);
                        carry = 5'd1;
                    end
                end
            end
        end
    endgenerate

    assign res = bcd ? dec_res : bin_res;
endmodule

// File: rtl/tmr_snapshot.sv
module tmr_snapshot #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch_req,
    input  logic [W-1:0] cur,
    output logic [W-1:0] snap
);
    logic [W-1:0] snap_d, snap_q;

    always_comb snap_d = latch_req ? cur : snap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) snap_q <= '0;
        else        snap_q <= snap_d;
    end

    assign snap = snap_q;

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_req |=> $stable(snap_q)); // R13
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         gate,
    input  logic         cfg_wr,
    input  logic [2:0]   cfg_mode,
    input  logic         cfg_bcd,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_val,
    input  logic         latch_req,
    output logic [W-1:0] rd_count,
    output logic         out
);
    import tmr_pkg::*;

    localparam logic [W-1:0] CNT_ONE = W'(1);
    localparam logic [W-1:0] CNT_TWO = W'(2);

    typedef struct packed {
        tmr_mode_e    mode;
        logic         bcd;
        logic [W-1:0] cr;
        logic [W-1:0] ce;
        logic         out;
        logic         run;
        logic         armed;
        logic         load_pend;
        logic         have_cnt;
        logic         trig_pend;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic gate_rise, trig;
    logic [W-1:0] ce_dec1, ce_dec2, cr_inc1, cr_dec1, hi_val, lo_val;
    tmr_mode_e new_mode;

    tmr_gate_edge u_gate (.clk(clk), .rst_n(rst_n), .gate(gate), .rise(gate_rise));

    tmr_step #(.W(W), .STEP(1), .UP(1'b0)) u_ce_dec1 (.val(st_q.ce), .bcd(st_q.bcd), .res(ce_dec1));
    tmr_step #(.W(W), .STEP(2), .UP(1'b0)) u_ce_dec2 (.val(st_q.ce), .bcd(st_q.bcd), .res(ce_dec2));
    tmr_step #(.W(W), .STEP(1), .UP(1'b1)) u_cr_inc1 (.val(st_q.cr), .bcd(st_q.bcd), .res(cr_inc1));
    tmr_step #(.W(W), .STEP(1), .UP(1'b0)) u_cr_dec1 (.val(st_q.cr), .bcd(st_q.bcd), .res(cr_dec1));

    tmr_snapshot #(.W(W)) u_snap (.clk(clk), .rst_n(rst_n), .latch_req(latch_req),
                                  .cur(st_q.ce), .snap(rd_count));

    // square-wave half periods: odd counts round the high half up
    assign hi_val   = st_q.cr[0] ? cr_inc1 : st_q.cr;
    assign lo_val   = st_q.cr[0] ? cr_dec1 : st_q.cr;
    assign trig     = st_q.trig_pend | gate_rise;
    assign new_mode = fold_mode(cfg_mode);

    always_comb begin
        st_d = st_q;
        st_d.trig_pend = trig;
        if (cfg_wr) begin
            st_d.mode      = new_mode;
            st_d.bcd       = cfg_bcd;
            st_d.out       = (new_mode != MD_TC_INT);
            st_d.run       = 1'b0;
            st_d.armed     = 1'b0;
            st_d.load_pend = 1'b0;
            st_d.have_cnt  = 1'b0;
            st_d.trig_pend = 1'b0;
        end
        if (cnt_wr) begin
            st_d.cr       = cnt_val;
            st_d.have_cnt = 1'b1;
            case (st_d.mode)
                MD_TC_INT, MD_SW_STROBE: begin
                    st_d.load_pend = 1'b1;
                    st_d.run       = 1'b0;
                    st_d.armed     = 1'b0;
                    st_d.out       = (st_d.mode == MD_SW_STROBE);
                end
                MD_RATE, MD_SQUARE: if (!st_d.run) st_d.load_pend = 1'b1;
                default: ;
            endcase
        end
        if (!cfg_wr && !cnt_wr) begin
            if ((st_q.mode == MD_RATE || st_q.mode == MD_SQUARE) && !gate)
                st_d.out = 1'b1;
            if (tick) begin
                st_d.trig_pend = 1'b0;
                case (st_q.mode)
                    MD_TC_INT, MD_SW_STROBE: begin
                        if (st_q.mode == MD_SW_STROBE && !st_q.out) st_d.out = 1'b1;
                        if (st_q.load_pend) begin
                            st_d.ce        = st_q.cr;
                            st_d.run       = 1'b1;
                            st_d.armed     = 1'b1;
                            st_d.load_pend = 1'b0;
                        end else if (st_q.run && gate) begin
                            st_d.ce = ce_dec1;
                            if (st_q.ce == CNT_ONE && st_q.armed) begin
                                st_d.armed = 1'b0;
                                st_d.out   = (st_q.mode == MD_TC_INT);
                            end
                        end
                    end
                    MD_ONESHOT, MD_HW_STROBE: begin
                        if (st_q.mode == MD_HW_STROBE && !st_q.out) st_d.out = 1'b1;
                        if (trig && st_q.have_cnt) begin
                            st_d.ce    = st_q.cr;
                            st_d.run   = 1'b1;
                            st_d.armed = 1'b1;
                            if (st_q.mode == MD_ONESHOT) st_d.out = 1'b0;
                        end else if (st_q.run) begin
                            st_d.ce = ce_dec1;
                            if (st_q.ce == CNT_ONE && st_q.armed) begin
                                st_d.armed = 1'b0;
                                st_d.out   = (st_q.mode == MD_ONESHOT);
                            end
                        end
                    end
                    MD_RATE, MD_SQUARE: if (gate) begin
                        if (st_q.load_pend || (trig && st_q.have_cnt)) begin
                            st_d.run       = 1'b1;
                            st_d.load_pend = 1'b0;
                            st_d.out       = 1'b1;
                            st_d.ce        = (st_q.mode == MD_SQUARE) ? hi_val : st_q.cr;
                        end else if (st_q.run) begin
                            if (st_q.mode == MD_RATE) begin
                                if (st_q.ce == CNT_ONE) begin
                                    st_d.ce  = st_q.cr;
                                    st_d.out = 1'b1;
                                end else begin
                                    st_d.ce  = ce_dec1;
                                    st_d.out = (st_q.ce != CNT_TWO);
                                end
                            end else if (st_q.ce == CNT_TWO) begin
                                st_d.out = ~st_q.out;
                                st_d.ce  = st_q.out ? lo_val : hi_val;
                            end else begin
                                st_d.ce = ce_dec2;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mode <= MD_TC_INT;
            st_q.out  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign out = st_q.out;

    AST_MODE0_OUT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_TC_INT && out && !cfg_wr && !cnt_wr) |=> out); // R2

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cfg_wr && !cnt_wr) |=> $stable(st_q.ce)); // R2

    AST_GATE_LOW_OUT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MD_RATE || st_q.mode == MD_SQUARE) && !gate && !cfg_wr && !cnt_wr)
        |=> out); // R8

    AST_STROBE_ONE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == MD_SW_STROBE || st_q.mode == MD_HW_STROBE) && tick && !out
         && !cfg_wr && !cnt_wr) |=> out); // R9

    AST_MODE_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (st_q.mode != 3'd6 && st_q.mode != 3'd7)); // R11
endmodule

// File: tb/tmr_channel_tb.sv
module tmr_channel_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, gate = 1'b1;
    logic cfg_wr = 1'b0, cfg_bcd = 1'b0, cnt_wr = 1'b0, latch_req = 1'b0;
    logic [2:0] cfg_mode = 3'd0;
    logic [W-1:0] cnt_val = '0;
    logic [W-1:0] rd_count;
    logic out;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_channel #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .gate(gate),
        .cfg_wr(cfg_wr), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
        .cnt_wr(cnt_wr), .cnt_val(cnt_val), .latch_req(latch_req),
        .rd_count(rd_count), .out(out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // all helpers start and end at a falling edge
    task automatic do_cfg(input logic [2:0] m, input logic b);
        cfg_wr = 1'b1; cfg_mode = m; cfg_bcd = b;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic do_cnt(input logic [W-1:0] v);
        cnt_wr = 1'b1; cnt_val = v;
        @(negedge clk);
        cnt_wr = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
        end
        tick = 1'b0;
    endtask

    task automatic do_trigger();
        gate = 1'b0;
        @(negedge clk);
        gate = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_latch();
        latch_req = 1'b1;
        @(negedge clk);
        latch_req = 1'b0;
    endtask

    // pat read left to right: first tick is bit n-1
    task automatic tick_pattern(input string req, input int n, input logic [15:0] pat);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            check(req, W'(out), W'(pat[n-1-i]));
        end
        tick = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 out", W'(out), W'(1));
        check("R1 rd_count", rd_count, '0);
    endtask

    task automatic t_mode0();
        do_cfg(3'd0, 1'b0);
        check("R2 out low after cfg", W'(out), W'(0));
        do_cnt(16'd5);
        tick_pattern("R2 mode0 N=5", 9, 16'b000001111);
        do_cnt(16'd3);
        check("R2 out low after rewrite", W'(out), W'(0));
        do_ticks(1);
        repeat (3) @(negedge clk);
        check("R2 no count without tick", W'(out), W'(0));
        tick_pattern("R2 first count tick", 1, 16'b0);
        gate = 1'b0;
        tick_pattern("R3 gate low holds", 4, 16'b0000);
        gate = 1'b1;
        tick_pattern("R3 resume", 2, 16'b01);
    endtask

    task automatic t_latch_bcd();
        do_cfg(3'd0, 1'b0);
        do_cnt(16'd100);
        do_ticks(11);
        do_latch();
        check("R13 snapshot", rd_count, 16'd90);
        do_ticks(5);
        check("R13 snapshot frozen", rd_count, 16'd90);
        do_latch();
        check("R13 snapshot refresh", rd_count, 16'd85);
        do_cnt(16'h0000);
        do_ticks(2);
        do_latch();
        check("R12 binary wrap", rd_count, 16'hFFFF);
        do_cfg(3'd0, 1'b1);
        do_cnt(16'h0100);
        do_ticks(2);
        do_latch();
        check("R12 bcd borrow", rd_count, 16'h0099);
        do_cnt(16'h0000);
        do_ticks(2);
        do_latch();
        check("R12 bcd wrap", rd_count, 16'h9999);
        do_cnt(16'h0010);
        do_ticks(4);
        do_latch();
        check("R12 bcd step", rd_count, 16'h0007);
    endtask

    task automatic t_mode1();
        do_cfg(3'd1, 1'b0);
        do_cnt(16'd3);
        tick_pattern("R4 idle before trigger", 2, 16'b11);
        do_trigger();
        tick_pattern("R4 one-shot", 4, 16'b0001);
        do_trigger();
        tick_pattern("R4 repeat", 4, 16'b0001);
        do_trigger();
        tick_pattern("R4 pre-retrigger", 2, 16'b00);
        do_trigger();
        tick_pattern("R4 retrigger", 4, 16'b0001);
        do_trigger();
        tick_pattern("R5 pulse start", 1, 16'b0);
        do_cnt(16'd5);
        tick_pattern("R5 old count continues", 3, 16'b001);
        do_trigger();
        tick_pattern("R5 new count used", 6, 16'b000001);
    endtask

    task automatic t_mode2();
        do_cfg(3'd2, 1'b0);
        do_cnt(16'd4);
        tick_pattern("R6 rate N=4", 8, 16'b11101110);
        do_cfg(3'd6, 1'b0);
        do_cnt(16'd3);
        tick_pattern("R11 code6 N=3", 6, 16'b110110);
        do_cfg(3'd2, 1'b0);
        do_cnt(16'd4);
        tick_pattern("R8 before gate", 3, 16'b111);
        gate = 1'b0;
        tick_pattern("R8 gate low high", 1, 16'b1);
        gate = 1'b1;
        tick_pattern("R8 restart", 4, 16'b1110);
    endtask

    task automatic t_mode3();
        do_cfg(3'd3, 1'b0);
        do_cnt(16'd5);
        tick_pattern("R7 square odd N=5", 9, 16'b111001110);
        do_cfg(3'd7, 1'b0);
        do_cnt(16'd4);
        tick_pattern("R11 code7 N=4", 8, 16'b11001100);
        gate = 1'b0;
        tick_pattern("R8 square gate low", 2, 16'b11);
        gate = 1'b1;
        tick_pattern("R8 square restart", 4, 16'b1100);
    endtask

    task automatic t_mode4();
        do_cfg(3'd4, 1'b0);
        check("R9 out high after cfg", W'(out), W'(1));
        do_cnt(16'd3);
        tick_pattern("R9 sw strobe", 7, 16'b1110111);
    endtask

    task automatic t_mode5();
        do_cfg(3'd5, 1'b0);
        do_cnt(16'd2);
        tick_pattern("R10 wait for gate", 2, 16'b11);
        do_trigger();
        tick_pattern("R10 hw strobe", 5, 16'b11011);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_latch_bcd();
        t_mode1();
        t_mode2();
        t_mode3();
        t_mode4();
        t_mode5();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule